// File: doc/BRIEF.md
# Threshold Alarm Engine

This block watches three inertial data streams (one per axis, each offering an acceleration value and an angle value) and one system stream (supply voltage or temperature). It runs four independent alarms and raises a sticky flag when a watched value crosses a programmed level. The three axis alarms can instead watch how much their value swings over a programmed number of samples. The system alarm always compares levels.

A single control word configures all four alarms. Each alarm has its own enable bit, source-select bit and direction bit, and each axis alarm also has a level/swing mode bit. The surrounding register file supplies the magnitudes and the sample-window lengths. New samples arrive on every stream together, marked by one valid strobe. Flags stay set until a clear pulse. An indicator output is the OR of the four flags, so it stays active until software clears them.

Top module: `tilt_alarm_engine`

## Requirements
- R1: After reset, all four flags and the indicator are 0.
- R2: In level mode, an axis alarm compares its selected value with its magnitude as signed 16-bit numbers. With the direction bit (ctrl bits 8, 9, 10 for X, Y, Z) at 0, it fires when value < magnitude. With the bit at 1, it fires when value > magnitude. Equal values never fire.
- R3: Ctrl bits 4, 5 and 6 pick the source for X, Y and Z. A 1 picks the angle input and a 0 picks the acceleration input.
- R4: The system alarm is enabled by ctrl bit 3. Ctrl bit 7 picks the source (1 = supply, 0 = temperature). Ctrl bit 11 sets the direction with the same meaning as in R2. Its comparison is unsigned, and it always works in level mode.
- R5: Ctrl bits 12, 13 and 14 set 1 = swing mode for X, Y and Z. Each axis keeps a reference sample, taken at the first valid sample after reset. Every P-th valid sample after the reference is an evaluation sample, where P is the axis window length and P = 0 acts as 1. On that sample the block computes diff = value − reference at full precision. With the direction bit at 1 it fires when diff > magnitude; with it at 0 it fires when diff < −magnitude. Evaluation then reloads the reference with the current value and restarts the count.
- R6: Ctrl bits 0 to 3 enable X, Y, Z and S. A disabled alarm never sets its flag. A flag that is already set stays set when its alarm is disabled.
- R7: A condition counts only on a cycle with sample_valid high. Its flag is visible from the next cycle on and stays set until cleared.
- R8: A clear pulse zeroes all flags in the next cycle. When a clear and a firing sample arrive in the same cycle, the clear wins.
- R9: The output alarm_flags holds X, Y, Z and S in bits 0 to 3. The indicator is high whenever any flag is set, and it falls only after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 16 | Per-alarm enable, source, direction and mode bits |
| mag_x | input | 16 | X magnitude (signed) |
| mag_y | input | 16 | Y magnitude (signed) |
| mag_z | input | 16 | Z magnitude (signed) |
| mag_s | input | 16 | System magnitude (unsigned) |
| win_x | input | 16 | X swing window in samples |
| win_y | input | 16 | Y swing window in samples |
| win_z | input | 16 | Z swing window in samples |
| accel_x | input | 16 | X acceleration sample |
| accel_y | input | 16 | Y acceleration sample |
| accel_z | input | 16 | Z acceleration sample |
| angle_x | input | 16 | X angle sample |
| angle_y | input | 16 | Y angle sample |
| angle_z | input | 16 | Z angle sample |
| supply_val | input | 16 | Supply measurement sample |
| temp_val | input | 16 | Temperature sample |
| sample_valid | input | 1 | All sample inputs are new this cycle |
| clear_flags | input | 1 | Clear all flags |
| alarm_flags | output | 4 | Sticky flags X, Y, Z, S |
| alarm_ind | output | 1 | OR of the flags |

## Verification
Some properties are checked by assertions on every cycle. Flags stay set unless a clear arrives, and a clear empties them. The indicator falls only after a clear. A flag rises only after a valid sample with its enable set. A level-mode value equal to its magnitude never fires. Each swing evaluation restarts the count and reloads the reference. Other behaviour only the bench scenarios can show: the signed and unsigned compare results across the value sweeps, the source routing, and the exact sample on which a swing window evaluates against an independently kept reference.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int EXT_W = 34;
  localparam int N_AXIS = 3;
  localparam int N_ALARM = N_AXIS + 1;
  localparam int EN_LSB = 0;
  localparam int SEL_LSB = 4;
  localparam int DIR_LSB = 8;
  localparam int MODE_LSB = 12;

  typedef logic signed [EXT_W-1:0] ext_t;

  function automatic logic level_hit(input ext_t v, input ext_t thr, input logic above);
    return above ? (v > thr) : (v < thr);
  endfunction

  function automatic logic swing_hit(input ext_t diff, input ext_t mag, input logic rise);
    return rise ? (diff > mag) : (diff < -mag);
  endfunction
endpackage

// File: rtl/alarm_channel.sv
module alarm_channel
  import alarm_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter bit SIGNED_CMP = 1'b1,
  parameter bit HAS_DYN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] val_a,
  input  logic [DW-1:0] val_b,
  input  logic          sel,
  input  logic          dir,
  input  logic          dyn_mode,
  input  logic          en,
  input  logic [DW-1:0] mag,
  input  logic [CW-1:0] period,
  output logic          trig
);
  function automatic ext_t widen(input logic [DW-1:0] x);
    if (SIGNED_CMP) return {{(EXT_W-DW){x[DW-1]}}, x};
    else            return {{(EXT_W-DW){1'b0}}, x};
  endfunction

  logic [DW-1:0] sel_val;
  logic          level_event;
  logic          hit;

  assign sel_val     = sel ? val_a : val_b;
  assign level_event = smp_valid && level_hit(widen(sel_val), widen(mag), dir);

  generate
    if (HAS_DYN) begin : g_dyn
      logic [DW-1:0] ref_q;
      logic [CW-1:0] cnt_q;
      logic          have_q;
      logic [CW:0]   cnt_nxt;
      logic [CW:0]   period_eff;
      logic          dyn_eval;
      logic          swing_event;

      assign cnt_nxt     = {1'b0, cnt_q} + 1'b1;
      assign period_eff  = (period == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, period};
      assign dyn_eval    = smp_valid && have_q && (cnt_nxt >= period_eff);
      assign swing_event = dyn_eval &&
                           swing_hit(widen(sel_val) - widen(ref_q), widen(mag), dir);
      assign hit = dyn_mode ? swing_event : level_event;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ref_q  <= '0;
          cnt_q  <= '0;
          have_q <= 1'b0;
        end else if (smp_valid) begin
          if (!have_q || dyn_eval) begin
            ref_q  <= sel_val;
            cnt_q  <= '0;
            have_q <= 1'b1;
          end else begin
            cnt_q <= cnt_nxt[CW-1:0];
          end
        end
      end

      AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        dyn_eval |=> (cnt_q == '0)); // R5
      AST_REF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dyn_eval |=> (ref_q == $past(sel_val))); // R5
    end else begin : g_static
      logic unused_dyn;
      assign unused_dyn = ^{dyn_mode, period};
      assign hit = level_event;
    end
  endgenerate

  assign trig = en && hit;

  AST_EQUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !(HAS_DYN && dyn_mode) && (sel_val == mag)) |-> !trig); // R2
endmodule

// File: rtl/alarm_flag_bank.sv
module alarm_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic [N-1:0] flags,
  output logic         ind
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   flags_q <= '0;
    else if (clr) flags_q <= '0;
    else          flags_q <= flags_q | set_vec;
  end

  assign flags = flags_q;
  assign ind   = |flags_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags_q == '0)); // R8
  AST_IND_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ind) |-> $past(clr)); // R9
endmodule

// File: rtl/tilt_alarm_engine.sv
module tilt_alarm_engine
  import alarm_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   ctrl_word,
  input  logic [DW-1:0] mag_x,
  input  logic [DW-1:0] mag_y,
  input  logic [DW-1:0] mag_z,
  input  logic [DW-1:0] mag_s,
  input  logic [CW-1:0] win_x,
  input  logic [CW-1:0] win_y,
  input  logic [CW-1:0] win_z,
  input  logic [DW-1:0] accel_x,
  input  logic [DW-1:0] accel_y,
  input  logic [DW-1:0] accel_z,
  input  logic [DW-1:0] angle_x,
  input  logic [DW-1:0] angle_y,
  input  logic [DW-1:0] angle_z,
  input  logic [DW-1:0] supply_val,
  input  logic [DW-1:0] temp_val,
  input  logic          sample_valid,
  input  logic          clear_flags,
  output logic [3:0]    alarm_flags,
  output logic          alarm_ind
);
  localparam int SYS = N_AXIS;

  logic [DW-1:0] accel_arr [N_AXIS];
  logic [DW-1:0] angle_arr [N_AXIS];
  logic [DW-1:0] mag_arr   [N_AXIS];
  logic [CW-1:0] win_arr   [N_AXIS];
  logic [N_ALARM-1:0] trig_vec;
  logic unused_ctrl;

  assign accel_arr = '{accel_x, accel_y, accel_z};
  assign angle_arr = '{angle_x, angle_y, angle_z};
  assign mag_arr   = '{mag_x, mag_y, mag_z};
  assign win_arr   = '{win_x, win_y, win_z};
  assign unused_ctrl = ctrl_word[15];

  generate
    for (genvar g = 0; g < N_AXIS; g++) begin : g_axis
      alarm_channel #(.DW(DW), .CW(CW), .SIGNED_CMP(1'b1), .HAS_DYN(1'b1)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (sample_valid),
        .val_a     (angle_arr[g]),
        .val_b     (accel_arr[g]),
        .sel       (ctrl_word[SEL_LSB+g]),
        .dir       (ctrl_word[DIR_LSB+g]),
        .dyn_mode  (ctrl_word[MODE_LSB+g]),
        .en        (ctrl_word[EN_LSB+g]),
        .mag       (mag_arr[g]),
        .period    (win_arr[g]),
        .trig      (trig_vec[g])
      );
    end
  endgenerate

  alarm_channel #(.DW(DW), .CW(CW), .SIGNED_CMP(1'b0), .HAS_DYN(1'b0)) u_sys (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (sample_valid),
    .val_a     (supply_val),
    .val_b     (temp_val),
    .sel       (ctrl_word[SEL_LSB+SYS]),
    .dir       (ctrl_word[DIR_LSB+SYS]),
    .dyn_mode  (1'b0),
    .en        (ctrl_word[EN_LSB+SYS]),
    .mag       (mag_s),
    .period    ({CW{1'b0}}),
    .trig      (trig_vec[SYS])
  );

  alarm_flag_bank #(.N(N_ALARM)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (trig_vec),
    .clr     (clear_flags),
    .flags   (alarm_flags),
    .ind     (alarm_ind)
  );

  generate
    for (genvar k = 0; k < N_ALARM; k++) begin : g_chk
      AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flags[k]) |-> $past(ctrl_word[EN_LSB+k] && sample_valid)); // R6
    end
  endgenerate
endmodule

// File: tb/tilt_alarm_engine_bench.sv
module tilt_alarm_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ctrl = '0;
  logic [15:0] mag [4];
  logic [15:0] win [3];
  logic [15:0] accel [3];
  logic [15:0] angle [3];
  logic [15:0] supply_v = '0;
  logic [15:0] temp_v = '0;
  logic valid = 1'b0;
  logic clr = 1'b0;
  logic [3:0] flags;
  logic ind;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tilt_alarm_engine u_tilt_alarm_engine (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl),
    .mag_x(mag[0]), .mag_y(mag[1]), .mag_z(mag[2]), .mag_s(mag[3]),
    .win_x(win[0]), .win_y(win[1]), .win_z(win[2]),
    .accel_x(accel[0]), .accel_y(accel[1]), .accel_z(accel[2]),
    .angle_x(angle[0]), .angle_y(angle[1]), .angle_z(angle[2]),
    .supply_val(supply_v), .temp_val(temp_v),
    .sample_valid(valid), .clear_flags(clr),
    .alarm_flags(flags), .alarm_ind(ind)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic do_sample();
    @(negedge clk); valid = 1'b1;
    @(negedge clk); valid = 1'b0;
  endtask

  logic [15:0] svals [6] = '{16'h8000, 16'hFFFF, 16'h0000, 16'h0001, 16'h7FFF, 16'h1234};
  logic [15:0] uvals [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

  initial begin
    for (int i = 0; i < 3; i++) begin
      mag[i] = '0; win[i] = '0; accel[i] = '0; angle[i] = '0;
    end
    mag[3] = '0;
    do_reset();
    // R1 reset state
    check("R1 flags", 32'(flags), 32'h0);
    check("R1 ind", 32'(ind), 32'h0);

    // R2 signed level sweep on X
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 6; b++) begin
          logic e;
          ctrl = 16'(32'h0001 | (d << 8));
          accel[0] = svals[a]; angle[0] = ~svals[a]; mag[0] = svals[b];
          do_clear();
          do_sample();
          e = d ? ($signed(svals[a]) > $signed(svals[b])) : ($signed(svals[a]) < $signed(svals[b]));
          check("R2 X level flag", 32'(flags), 32'(e));
          check("R9 ind follows flag", 32'(ind), 32'(e));
        end

    // R3 source select on each axis
    for (int i = 0; i < 3; i++)
      for (int s = 0; s < 2; s++) begin
        for (int j = 0; j < 3; j++) begin accel[j] = '0; angle[j] = '0; mag[j] = 16'h7FFF; end
        accel[i] = 16'h0100; angle[i] = 16'h3000; mag[i] = 16'h2000;
        ctrl = 16'((1 << i) | (s << (4 + i)) | (1 << (8 + i)));
        do_clear();
        do_sample();
        check("R3 source select", 32'(flags), 32'(s << i));
      end

    // R4 unsigned system sweep
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 2; d++)
        for (int a = 0; a < 5; a++)
          for (int b = 0; b < 5; b++) begin
            logic e;
            ctrl = 16'(32'h0008 | (s << 7) | (d << 11));
            if (s) begin supply_v = uvals[a]; temp_v = ~uvals[a]; end
            else begin temp_v = uvals[a]; supply_v = ~uvals[a]; end
            mag[3] = uvals[b];
            do_clear();
            do_sample();
            e = d ? (uvals[a] > uvals[b]) : (uvals[a] < uvals[b]);
            check("R4 system flag", 32'(flags), 32'(e) << 3);
          end

    // R6 enables
    for (int j = 0; j < 3; j++) begin accel[j] = 16'h0100; angle[j] = 16'h0100; mag[j] = 16'h0000; end
    supply_v = 16'h0100; temp_v = 16'h0100; mag[3] = 16'h0000;
    ctrl = 16'h0F00;
    do_clear();
    do_sample();
    check("R6 all disabled", 32'(flags), 32'h0);
    ctrl = 16'h0F01;
    do_sample();
    check("R6 X only enabled", 32'(flags), 32'h1);
    ctrl = 16'h0F00;
    do_sample();
    check("R6 set flag kept after disable", 32'(flags), 32'h1);
    ctrl = 16'h0F0C;
    do_sample();
    check("R6 Z and S enabled", 32'(flags), 32'hD);

    // R7 valid gating and stickiness
    ctrl = 16'h0001; accel[0] = 16'hFFFB; mag[0] = 16'h0000;
    do_clear();
    repeat (3) @(negedge clk);
    check("R7 no valid no flag", 32'(flags), 32'h0);
    do_sample();
    check("R7 flag after valid", 32'(flags), 32'h1);
    accel[0] = 16'h0005;
    do_sample();
    repeat (4) @(negedge clk);
    check("R7 flag sticky", 32'(flags), 32'h1);
    check("R9 ind held", 32'(ind), 32'h1);

    // R8 clear wins over same-cycle trigger
    accel[0] = 16'hFFFB;
    @(negedge clk); valid = 1'b1; clr = 1'b1;
    @(negedge clk); valid = 1'b0; clr = 1'b0;
    check("R8 clear priority", 32'(flags), 32'h0);
    check("R9 ind low after clear", 32'(ind), 32'h0);

    // R5 swing mode on Y
    for (int d = 0; d < 2; d++)
      for (int pi = 0; pi < 3; pi++) begin
        int p;
        int pe;
        int rf;
        int cnt;
        bit have;
        bit ef;
        p = (pi == 0) ? 0 : (pi == 1) ? 1 : 3;
        pe = (p == 0) ? 1 : p;
        ctrl = 16'(32'h0002 | (d << 9) | (1 << 13));
        mag[1] = 16'h0100; win[1] = 16'(p);
        do_reset();
        have = 0; rf = 0; cnt = 0; ef = 0;
        for (int k = 0; k < 24; k++) begin
          int v;
          if (k % 5 == 4) begin do_clear(); ef = 0; end
          v = ((k * k * 53 + k * 311) % 1024) - 512;
          accel[1] = 16'(v);
          do_sample();
          if (!have) begin rf = v; have = 1; cnt = 0; end
          else if (cnt + 1 >= pe) begin
            int df;
            df = v - rf;
            if (d ? (df > 256) : (df < -256)) ef = 1;
            rf = v; cnt = 0;
          end else cnt++;
          check("R5 swing flag", 32'(flags), 32'(ef) << 1);
        end
      end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule